// File: doc/BRIEF.md
# Interlace-Capable Raster Timing Generator

This block produces the raster timing for one display output and paces pixels from an upstream compositor through a small output byte FIFO. Software programs it through a simple word-wide register port. Horizontal timing is set by four fields, and so is vertical timing. A second vertical set is used for the even field when interlace is on. Every line and every frame runs through back porch, sync, front porch and then the active region. The block drives hsync, vsync, data-enable, the field flag and a frame-start strobe. The compositor begins producing pixels on that strobe.

The FIFO counts bytes. Its fill threshold, and the number of bytes each pixel takes, follow the pixel-format code. The compositor may push while `pix_ready` is high. A pixel is taken on each data-enable cycle when enough bytes are present. An empty FIFO during active video can raise an underflow flag. A second interrupt source fires when the vertical front porch begins.

Top module: `raster_timer`

## Requirements
- R1: Each line is hbp+hsw+hfp+hact cycles long. hsync is high during cycles hbp to hbp+hsw-1 of the line, and the last hact cycles are the horizontal active region. Register 2 holds hbp in bits [11:0] and hsw in bits [27:16]. Register 3 holds hfp in bits [11:0] and hact in bits [27:16].
- R2: Each frame is vbp+vsw+vfp+vact lines, in that order. vsync is high on lines vbp to vbp+vsw-1. The odd-field set lives in registers 4 (vbp [11:0], vsw [27:16]) and 5 (vfp [11:0], vact [27:16]).
- R3: de is high exactly when the horizontal and the vertical position are both in their active regions, and never together with hsync or vsync.
- R4: Register 1 bit 2 selects interlace. In interlace mode the field output toggles at each frame wrap, and the field-1 frames use the even set in registers 6 and 7, which have the same layout as 4 and 5. In progressive mode the field output stays 0.
- R5: Status register 9 bit 0 is set when the vertical front porch begins. irq is high while a status bit and the matching bit of enable register 8 are both 1. Writing 1 to a status bit clears it.
- R6: Register 1 bit 0 requests video and bit 1 selects continuous mode. In continuous mode frames repeat until the request is cleared. The block then finishes the current frame. Bit 0 reads back as 1 until the frame has ended and as 0 afterwards.
- R7: With continuous mode off, one frame runs and the block then stops by itself. Bit 0 then reads back as 0.
- R8: The FIFO holds 64 bytes. Control register 0 bits [2:0] give the format: codes 0 and 1 are 16-bit (2 bytes, threshold 52), code 2 is 18-bit (3 bytes, threshold 50), and codes 3 and above are 24-bit (3 bytes, threshold 46). pix_ready is high while the level is below the threshold.
- R9: Writing control bit 3 as 1 empties the FIFO. With control bit 4 set, the FIFO is also emptied at every frame start.
- R10: With control bit 6 set, no pixel is taken and no underflow is flagged until the first line of a run has ended.
- R11: With control bit 5 set, a data-enable cycle with fewer bytes than one pixel sets status bit 1. With bit 5 clear, status bit 1 stays 0.
- R12: frame_start is a single-cycle pulse in the first cycle of every frame while video runs.
- R13: Writes to the timing registers take effect at the next frame start, never within the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| pix_valid | input | 1 | Compositor offers one pixel |
| pix_ready | output | 1 | FIFO level below the format threshold |
| pix_take | output | 1 | One pixel leaves the FIFO this cycle |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| field | output | 1 | Current field, 1 = even |
| frame_start | output | 1 | Start-of-frame strobe toward the compositor |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 64-byte FIFO and a pixel-latency allowance of 6. These defaults give the three distinct thresholds (52, 50, 46), so fill counts of 26, 17 and 16 pushes can be observed at the ports. Timing fields are kept tiny, with 12-cycle lines and 2- to 7-line frames. Whole frames are then compared cycle by cycle, and the exact cycles of the front-porch interrupt, the stop at the frame end and the delayed underflow under wait-for-line can be hit.

// File: rtl/rt_pkg.sv
// Shared types, register addresses and format helpers for the raster timer.
// Assumes 12-bit timing fields and a single pixel clock domain.
package rt_pkg;

    localparam int FW         = 12;  // timing field width
    localparam int EXTRA_18   = 14;  // threshold reserve for the 18-bit format

    typedef struct packed {
        logic [FW-1:0] bp;
        logic [FW-1:0] sw;
        logic [FW-1:0] fp;
        logic [FW-1:0] act;
    } seg_t;

    typedef enum logic [3:0] {
        ADR_CTRL    = 4'd0,
        ADR_VID     = 4'd1,
        ADR_HA      = 4'd2,
        ADR_HB      = 4'd3,
        ADR_VA_ODD  = 4'd4,
        ADR_VB_ODD  = 4'd5,
        ADR_VA_EVEN = 4'd6,
        ADR_VB_EVEN = 4'd7,
        ADR_IEN     = 4'd8,
        ADR_ISTAT   = 4'd9
    } reg_adr_e;

    typedef enum logic [2:0] {
        FMT_16A = 3'd0,
        FMT_16B = 3'd1,
        FMT_18  = 3'd2,
        FMT_24  = 3'd3
    } fmt_e;

    // Bytes one pixel occupies for a format code.
    function automatic int fmt_bytes(input logic [2:0] fmt);
        case (fmt)
            FMT_16A, FMT_16B: return 2;
            default:          return 3;
        endcase
    endfunction

    // FIFO fill threshold for a format code.
    function automatic int fmt_thresh(input logic [2:0] fmt, input int depth, input int lat);
        case (fmt)
            FMT_16A, FMT_16B: return depth - 2 * lat;
            FMT_18:           return depth - EXTRA_18;
            default:          return depth - 3 * lat;
        endcase
    endfunction

    // Total length of a segment set.
    function automatic logic [FW+1:0] seg_total(input seg_t s);
        return {2'b00, s.bp} + {2'b00, s.sw} + {2'b00, s.fp} + {2'b00, s.act};
    endfunction

endpackage

// File: rtl/rt_regs.sv
// Register file: timing sets, control bits, interrupt enable and status.
// Assumes single-cycle writes. Reads are combinational on the address.
// Video enable is passed on as set/clear pulses.
module rt_regs
    import rt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        running,
    input  logic        vfp_evt,
    input  logic        unf_evt,
    output seg_t        h_cfg,
    output seg_t        v_odd,
    output seg_t        v_even,
    output logic [2:0]  fmt,
    output logic        clr_start,
    output logic        trig_unf,
    output logic        wait_hs,
    output logic        cont,
    output logic        ilace,
    output logic        fifo_clr,
    output logic        en_set,
    output logic        en_clr,
    output logic [1:0]  istat,
    output logic        irq
);

    logic [1:0] ien;
    logic       vid_req;
    logic       wr_ctrl, wr_vid, wr_stat;

    // Decode of write targets that cause pulses.
    always_comb begin
        wr_ctrl  = reg_wr && (reg_addr == ADR_CTRL);
        wr_vid   = reg_wr && (reg_addr == ADR_VID);
        wr_stat  = reg_wr && (reg_addr == ADR_ISTAT);
        fifo_clr = wr_ctrl && reg_wdata[3];
        en_set   = wr_vid && reg_wdata[0];
        en_clr   = wr_vid && !reg_wdata[0];
        irq      = |(istat & ien);
    end

    // Register storage and status set/clear (a new event wins over a clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_cfg     <= '0;
            v_odd     <= '0;
            v_even    <= '0;
            fmt       <= FMT_24;
            clr_start <= 1'b0;
            trig_unf  <= 1'b0;
            wait_hs   <= 1'b0;
            cont      <= 1'b0;
            ilace     <= 1'b0;
            vid_req   <= 1'b0;
            ien       <= '0;
            istat     <= '0;
        end else begin
            istat <= (istat & ~(wr_stat ? reg_wdata[1:0] : 2'b00)) | {unf_evt, vfp_evt};
            if (reg_wr) begin
                case (reg_addr)
                    ADR_CTRL: begin
                        fmt       <= reg_wdata[2:0];
                        clr_start <= reg_wdata[4];
                        trig_unf  <= reg_wdata[5];
                        wait_hs   <= reg_wdata[6];
                    end
                    ADR_VID: begin
                        vid_req <= reg_wdata[0];
                        cont    <= reg_wdata[1];
                        ilace   <= reg_wdata[2];
                    end
                    ADR_HA:      begin h_cfg.bp  <= reg_wdata[FW-1:0];  h_cfg.sw  <= reg_wdata[FW+15:16]; end
                    ADR_HB:      begin h_cfg.fp  <= reg_wdata[FW-1:0];  h_cfg.act <= reg_wdata[FW+15:16]; end
                    ADR_VA_ODD:  begin v_odd.bp  <= reg_wdata[FW-1:0];  v_odd.sw  <= reg_wdata[FW+15:16]; end
                    ADR_VB_ODD:  begin v_odd.fp  <= reg_wdata[FW-1:0];  v_odd.act <= reg_wdata[FW+15:16]; end
                    ADR_VA_EVEN: begin v_even.bp <= reg_wdata[FW-1:0];  v_even.sw <= reg_wdata[FW+15:16]; end
                    ADR_VB_EVEN: begin v_even.fp <= reg_wdata[FW-1:0];  v_even.act <= reg_wdata[FW+15:16]; end
                    ADR_IEN:     ien <= reg_wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    // Read mux; the video bit reports the live running state.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_CTRL:    reg_rdata = {25'd0, wait_hs, trig_unf, clr_start, 1'b0, fmt};
            ADR_VID:     reg_rdata = {29'd0, ilace, cont, running};
            ADR_HA:      reg_rdata = {4'd0, h_cfg.sw, 4'd0, h_cfg.bp};
            ADR_HB:      reg_rdata = {4'd0, h_cfg.act, 4'd0, h_cfg.fp};
            ADR_VA_ODD:  reg_rdata = {4'd0, v_odd.sw, 4'd0, v_odd.bp};
            ADR_VB_ODD:  reg_rdata = {4'd0, v_odd.act, 4'd0, v_odd.fp};
            ADR_VA_EVEN: reg_rdata = {4'd0, v_even.sw, 4'd0, v_even.bp};
            ADR_VB_EVEN: reg_rdata = {4'd0, v_even.act, 4'd0, v_even.fp};
            ADR_IEN:     reg_rdata = {30'd0, ien};
            ADR_ISTAT:   reg_rdata = {30'd0, istat};
            default:     reg_rdata = {31'd0, vid_req};
        endcase
    end

endmodule

// File: rtl/rt_timing.sv
// Horizontal/vertical counters, shadowed timing sets, sync/de generation,
// field tracking, and the wait-for-line gate. Timing sets are sampled only at
// run start and at each frame wrap. Assumes every total is at least 2.
module rt_timing
    import rt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  seg_t  h_cfg,
    input  seg_t  v_odd,
    input  seg_t  v_even,
    input  logic  cont,
    input  logic  ilace,
    input  logic  wait_hs,
    input  logic  en_set,
    input  logic  en_clr,
    output logic  running,
    output logic  hsync,
    output logic  vsync,
    output logic  de,
    output logic  field,
    output logic  frame_start,
    output logic  frame_end,
    output logic  vfp_evt,
    output logic  out_gate
);

    localparam int TW = FW + 2;

    logic [TW-1:0] h, v;
    logic [TW-1:0] htot, vtot;
    logic [TW-1:0] h_sync0, h_act0, v_sync0, v_act0, v_fp0;
    seg_t          sh_h, sh_v;
    logic          en_req, hold, h_last, v_last, nxt_field;

    // Region boundaries derived from the active shadow sets.
    always_comb begin
        htot    = seg_total(sh_h);
        vtot    = seg_total(sh_v);
        h_sync0 = {2'b00, sh_h.bp};
        h_act0  = h_sync0 + {2'b00, sh_h.sw} + {2'b00, sh_h.fp};
        v_sync0 = {2'b00, sh_v.bp};
        v_fp0   = v_sync0 + {2'b00, sh_v.sw};
        v_act0  = v_fp0 + {2'b00, sh_v.fp};
        h_last  = (h + 1'b1) >= htot;
        v_last  = (v + 1'b1) >= vtot;
        nxt_field = ilace && !field;
    end

    // Output strobes and levels decoded from the counters.
    always_comb begin
        hsync       = running && (h >= h_sync0) && (h < h_sync0 + {2'b00, sh_h.sw});
        vsync       = running && (v >= v_sync0) && (v < v_fp0);
        de          = running && (h >= h_act0) && (v >= v_act0);
        frame_start = running && (h == '0) && (v == '0);
        frame_end   = running && h_last && v_last;
        vfp_evt     = running && (h == '0) && (v == v_fp0);
        out_gate    = running && !hold;
    end

    // Run control, counters, shadow reload and field toggling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_req  <= 1'b0;
            running <= 1'b0;
            hold    <= 1'b0;
            h       <= '0;
            v       <= '0;
            field   <= 1'b0;
            sh_h    <= '0;
            sh_v    <= '0;
        end else begin
            if (!running) begin
                if (en_req) begin
                    running <= 1'b1;
                    hold    <= wait_hs;
                    h       <= '0;
                    v       <= '0;
                    field   <= 1'b0;
                    sh_h    <= h_cfg;
                    sh_v    <= v_odd;
                end
            end else if (h_last) begin
                h    <= '0;
                hold <= 1'b0;
                if (v_last) begin
                    v <= '0;
                    if (en_req && cont) begin
                        field <= nxt_field;
                        sh_h  <= h_cfg;
                        sh_v  <= nxt_field ? v_even : v_odd;
                    end else begin
                        running <= 1'b0;
                        field   <= 1'b0;
                        if (!cont) en_req <= 1'b0;
                    end
                end else begin
                    v <= v + 1'b1;
                end
            end else begin
                h <= h + 1'b1;
            end
            if (en_set)      en_req <= 1'b1;
            else if (en_clr) en_req <= 1'b0;
        end
    end

endmodule

// File: rtl/rt_fifo.sv
// Byte-counting output FIFO model: push from the compositor, one pixel taken
// per gated de cycle, format-dependent threshold and underflow detection.
// Assumes the compositor only pushes while pix_ready is high.
module rt_fifo
    import rt_pkg::*;
#(
    parameter int DEPTH_B = 64,
    parameter int LAT_PIX = 6,
    localparam int LW     = $clog2(DEPTH_B) + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    fmt,
    input  logic          fifo_clr,
    input  logic          clr_start,
    input  logic          frame_start,
    input  logic          pix_valid,
    input  logic          de,
    input  logic          out_gate,
    input  logic          trig_unf,
    output logic          pix_ready,
    output logic          pix_take,
    output logic          unf_evt,
    output logic [LW-1:0] level
);

    logic [LW-1:0] bpp, thr;
    logic          push;

    // Per-format sizes and flow decisions.
    always_comb begin
        bpp       = LW'(fmt_bytes(fmt));
        thr       = LW'(fmt_thresh(fmt, DEPTH_B, LAT_PIX));
        pix_ready = level < thr;
        push      = pix_valid && pix_ready;
        pix_take  = de && out_gate && (level >= bpp);
        unf_evt   = trig_unf && de && out_gate && (level < bpp);
    end

    // Level update with clear and clear-at-frame-start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else if (fifo_clr || (clr_start && frame_start)) begin
            level <= '0;
        end else begin
            level <= level + (push ? bpp : '0) - (pix_take ? bpp : '0);
        end
    end

endmodule

// File: rtl/raster_timer.sv
// Top of the raster timing generator: registers, timing core and FIFO pacer.
// Single clock, synchronous active-low reset.
module raster_timer
    import rt_pkg::*;
#(
    parameter int FIFO_BYTES = 64,
    parameter int LAT_PIX    = 6,
    localparam int LW        = $clog2(FIFO_BYTES) + 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        pix_valid,
    output logic        pix_ready,
    output logic        pix_take,
    output logic        hsync,
    output logic        vsync,
    output logic        de,
    output logic        field,
    output logic        frame_start,
    output logic        irq
);

    seg_t          h_cfg, v_odd, v_even;
    logic [2:0]    fmt;
    logic          clr_start, trig_unf, wait_hs, cont, ilace;
    logic          fifo_clr, en_set, en_clr, running, frame_end;
    logic          vfp_evt, unf_evt, out_gate;
    logic [1:0]    istat;
    logic [LW-1:0] level;

    rt_regs u_regs (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .running, .vfp_evt, .unf_evt,
        .h_cfg, .v_odd, .v_even, .fmt, .clr_start, .trig_unf, .wait_hs,
        .cont, .ilace, .fifo_clr, .en_set, .en_clr, .istat, .irq
    );

    rt_timing u_timing (
        .clk, .rst_n, .h_cfg, .v_odd, .v_even, .cont, .ilace, .wait_hs,
        .en_set, .en_clr, .running, .hsync, .vsync, .de, .field,
        .frame_start, .frame_end, .vfp_evt, .out_gate
    );

    rt_fifo #(.DEPTH_B(FIFO_BYTES), .LAT_PIX(LAT_PIX)) u_fifo (
        .clk, .rst_n, .fmt, .fifo_clr, .clr_start, .frame_start, .pix_valid,
        .de, .out_gate, .trig_unf, .pix_ready, .pix_take, .unf_evt, .level
    );

endmodule

// File: rtl/raster_timer_chk.sv
// Property checker for raster_timer, attached by bind.
module raster_timer_chk #(
    parameter int LW    = 8,
    parameter int DEPTH = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hsync,
    input logic          vsync,
    input logic          de,
    input logic          field,
    input logic          frame_start,
    input logic          running,
    input logic          frame_end,
    input logic          vfp_evt,
    input logic          unf_evt,
    input logic [1:0]    istat,
    input logic          pix_take,
    input logic [LW-1:0] level
);

    a_r3_de_apart_from_sync: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (!hsync && !vsync));

    a_r12_start_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    a_r4_field_moves_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !$stable(field)) |-> frame_start);

    a_r5_vfp_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        vfp_evt |=> istat[0]);

    a_r11_underflow_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        unf_evt |=> istat[1]);

    a_r11_take_only_in_active: assert property (@(posedge clk) disable iff (!rst_n)
        pix_take |-> de);

    a_r8_level_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    a_r6_stop_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> $past(frame_end));

endmodule

bind raster_timer raster_timer_chk #(.LW(LW), .DEPTH(FIFO_BYTES)) u_chk (
    .clk, .rst_n, .hsync, .vsync, .de, .field, .frame_start, .running,
    .frame_end, .vfp_evt, .unf_evt, .istat, .pix_take, .level
);

// File: tb/test_raster_timer.sv
// Directed bench for raster_timer: one task per scenario.
module test_raster_timer;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pix_valid = 1'b0;
    logic        pix_ready, pix_take, hsync, vsync, de, field, frame_start, irq;

    int checks = 0;
    int fails  = 0;

    raster_timer i_raster_timer (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .pix_valid, .pix_ready, .pix_take, .hsync, .vsync, .de, .field,
        .frame_start, .irq
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        pix_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_reg(input int a, input int d);
        reg_addr = 4'(a);
        reg_wdata = d;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input int a, output int d);
        reg_addr = 4'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic set_timing(input int hbp, hs, hfp, ha, vbp, vs, vfp, va);
        write_reg(2, (hs << 16) | hbp);
        write_reg(3, (ha << 16) | hfp);
        write_reg(4, (vs << 16) | vbp);
        write_reg(5, (va << 16) | vfp);
    endtask

    task automatic wait_frame_start();
        for (int i = 0; i < 2000; i++) begin
            if (frame_start) return;
            @(negedge clk);
        end
        check(0, "R12 frame_start never seen", 0, 1);
    endtask

    // Compare one whole frame cycle by cycle; starts at a frame_start negedge.
    task automatic check_frame(input int hbp, hs, hfp, ha, vbp, vs, vfp, va,
                               input bit fld, input string tag);
        int ht = hbp + hs + hfp + ha;
        int vt = vbp + vs + vfp + va;
        int e_hs = 0, e_vs = 0, e_de = 0, e_fl = 0, e_fs = 0;
        for (int c = 0; c < ht * vt; c++) begin
            int hh = c % ht;
            int vv = c / ht;
            bit x_hs = (hh >= hbp) && (hh < hbp + hs);
            bit x_vs = (vv >= vbp) && (vv < vbp + vs);
            bit x_de = (hh >= hbp + hs + hfp) && (vv >= vbp + vs + vfp);
            if (hsync != x_hs) e_hs++;
            if (vsync != x_vs) e_vs++;
            if (de != x_de) e_de++;
            if (field != fld) e_fl++;
            if (frame_start != (c == 0)) e_fs++;
            @(negedge clk);
        end
        check(e_hs == 0, {"R1 hsync pattern ", tag}, e_hs, 0);
        check(e_vs == 0, {"R2 vsync pattern ", tag}, e_vs, 0);
        check(e_de == 0, {"R3 de pattern ", tag}, e_de, 0);
        check(e_fl == 0, {"R4 field value ", tag}, e_fl, 0);
        check(e_fs == 0, {"R12 frame_start pulse ", tag}, e_fs, 0);
    endtask

    task automatic t_reset_state();
        int d;
        do_reset();
        @(negedge clk);
        check(!hsync && !vsync && !de && !frame_start && !irq, "R12 outputs idle after reset",
              {hsync, vsync, de, frame_start, irq}, 0);
        check(pix_ready, "R8 pix_ready after reset", pix_ready, 1);
        read_reg(1, d);
        check((d & 1) == 0, "R6 video bit after reset", d & 1, 0);
    endtask

    task automatic t_progressive_frames();
        do_reset();
        set_timing(2, 3, 1, 6, 1, 2, 1, 3);
        write_reg(1, 3);
        wait_frame_start();
        check_frame(2, 3, 1, 6, 1, 2, 1, 3, 1'b0, "progressive f0");
        check_frame(2, 3, 1, 6, 1, 2, 1, 3, 1'b0, "progressive f1");
    endtask

    task automatic t_interlace();
        do_reset();
        set_timing(2, 3, 1, 6, 2, 1, 1, 3);
        write_reg(6, (1 << 16) | 1);
        write_reg(7, (3 << 16) | 1);
        write_reg(1, 7);
        wait_frame_start();
        check_frame(2, 3, 1, 6, 2, 1, 1, 3, 1'b0, "odd field");
        check_frame(2, 3, 1, 6, 1, 1, 1, 3, 1'b1, "even field");
        check_frame(2, 3, 1, 6, 2, 1, 1, 3, 1'b0, "odd again");
    endtask

    task automatic t_shadow_boundary();
        do_reset();
        set_timing(2, 3, 1, 6, 1, 2, 1, 3);
        write_reg(1, 3);
        wait_frame_start();
        fork
            check_frame(2, 3, 1, 6, 1, 2, 1, 3, 1'b0, "R13 old timing kept");
            begin
                repeat (20) @(negedge clk);
                write_reg(3, (4 << 16) | 2);
            end
        join
        check_frame(2, 3, 2, 4, 1, 2, 1, 3, 1'b0, "R13 new timing used");
    endtask

    task automatic t_vfp_irq();
        int d;
        do_reset();
        set_timing(2, 3, 1, 6, 1, 2, 1, 3);
        write_reg(8, 1);
        write_reg(1, 3);
        wait_frame_start();
        repeat (36) @(negedge clk);
        check(!irq, "R5 irq before front porch", irq, 0);
        @(negedge clk);
        check(irq, "R5 irq at front porch start", irq, 1);
        write_reg(8, 0);
        check(!irq, "R5 irq masked by enable", irq, 0);
        read_reg(9, d);
        check((d & 1) == 1, "R5 status kept while masked", d & 1, 1);
        write_reg(9, 1);
        read_reg(9, d);
        check((d & 1) == 0, "R5 status cleared by write-one", d & 1, 0);
    endtask

    task automatic t_stop_continuous();
        int d;
        int starts = 0;
        do_reset();
        set_timing(2, 3, 1, 6, 1, 2, 1, 3);
        write_reg(1, 3);
        wait_frame_start();
        repeat (10) @(negedge clk);
        write_reg(1, 2);
        read_reg(1, d);
        check((d & 1) == 1, "R6 still running after clear", d & 1, 1);
        repeat (84 - 1 - 11) @(negedge clk);
        read_reg(1, d);
        check((d & 1) == 1, "R6 running in last frame cycle", d & 1, 1);
        @(negedge clk);
        read_reg(1, d);
        check((d & 1) == 0, "R6 stopped after frame end", d & 1, 0);
        for (int i = 0; i < 200; i++) begin
            if (frame_start) starts++;
            @(negedge clk);
        end
        check(starts == 0, "R6 no frame after stop", starts, 0);
    endtask

    task automatic t_one_shot();
        int d;
        int starts = 0;
        do_reset();
        set_timing(2, 3, 1, 6, 1, 2, 1, 3);
        write_reg(1, 1);
        wait_frame_start();
        repeat (84) @(negedge clk);
        for (int i = 0; i < 252; i++) begin
            if (frame_start) starts++;
            @(negedge clk);
        end
        check(starts == 0, "R7 single frame only", starts, 0);
        read_reg(1, d);
        check((d & 1) == 0, "R7 video bit reads 0", d & 1, 0);
    endtask

    task automatic t_threshold(input int fmt, input int exp_pushes);
        int n = 0;
        do_reset();
        write_reg(0, fmt | 8);
        pix_valid = 1'b1;
        for (int i = 0; i < 100; i++) begin
            if (!pix_ready) break;
            n++;
            @(negedge clk);
        end
        pix_valid = 1'b0;
        check(n == exp_pushes, $sformatf("R8 pushes to threshold fmt %0d", fmt), n, exp_pushes);
        write_reg(0, fmt | 8);
        check(pix_ready, "R9 clear empties FIFO", pix_ready, 1);
    endtask

    task automatic t_clear_at_start(input bit use_clr);
        do_reset();
        set_timing(2, 3, 1, 6, 1, 2, 1, 3);
        write_reg(0, 3 | (use_clr ? 16 : 0));
        pix_valid = 1'b1;
        for (int i = 0; i < 40 && pix_ready; i++) @(negedge clk);
        pix_valid = 1'b0;
        write_reg(1, 3);
        wait_frame_start();
        check(!pix_ready, "R9 FIFO full at frame start", pix_ready, 0);
        @(negedge clk);
        check(pix_ready == use_clr, "R9 clear-at-start effect", pix_ready, use_clr);
    endtask

    task automatic t_underflow(input int ctrl, input int probe0, input int exp0,
                               input int probe1, input int exp1, input string tag);
        int d;
        do_reset();
        set_timing(2, 3, 1, 6, 0, 0, 0, 2);
        write_reg(0, ctrl);
        write_reg(1, 3);
        wait_frame_start();
        repeat (probe0) @(negedge clk);
        read_reg(9, d);
        check(((d >> 1) & 1) == exp0, {tag, " early probe"}, (d >> 1) & 1, exp0);
        repeat (probe1 - probe0) @(negedge clk);
        read_reg(9, d);
        check(((d >> 1) & 1) == exp1, {tag, " late probe"}, (d >> 1) & 1, exp1);
    endtask

    initial begin
        #(PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_progressive_frames();
        t_interlace();
        t_shadow_boundary();
        t_vfp_irq();
        t_stop_continuous();
        t_one_shot();
        t_threshold(0, 26);
        t_threshold(1, 26);
        t_threshold(2, 17);
        t_threshold(3, 16);
        t_threshold(7, 16);
        t_clear_at_start(1'b1);
        t_clear_at_start(1'b0);
        t_underflow(3 | 32 | 64, 12, 0, 19, 1, "R10 wait for line end");
        t_underflow(3 | 32, 6, 0, 7, 1, "R11 underflow flagged");
        t_underflow(3, 7, 0, 30, 0, "R11 underflow disabled");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule